// File: doc/BRIEF.md
# Byte-Wide Configuration Loader

This block is a hardware master that pushes a configuration image into a target device over a byte-wide slave port. A start pulse begins a load. The block then drives the target's program request and waits for the target to signal that it is initialising. It releases the request and waits until the target reports that it is neither initialising nor busy. Then it enables the port, with select and write asserted together, and streams bytes from a valid/ready source. Each byte goes onto the bus while the configuration clock is high. The clock then drops for one half-period and rises again, and the target captures the byte on that rising edge.

While bytes are streaming, the loader holds back the next byte as long as the target reports busy. It stops at once if the target reports completion early, and it aborts if the target raises its initialisation line again, which signals a configuration error. After the last byte it releases select and write and keeps toggling the configuration clock until completion is reported with initialisation inactive. The result is either a pass or a fail with a cause code. Every failure also raises a single-cycle abort pulse.

A runtime prescaler input sets the half-period of the configuration clock. All waits and timeouts are counted in these half-period ticks, with limits taken from parameters.

Top module: `cfg_byte_loader`

## Requirements
- R1: After reset, tgtProg, tgtSelect and tgtWrite are 0, tgtCclk is 1, inReady is 0, and loading, passed and failed are all 0.
- R2: A start pulse raises tgtProg for at least PROG_TICKS ticks, where one tick is cfgHalfPeriod+1 clock cycles. tgtProg then stays high until tgtInitAct is seen. If tgtInitAct does not appear within INIT_TO ticks, the load fails with cause 1.
- R3: After tgtProg drops, tgtSelect and tgtWrite rise together, and only after a tick on which tgtInitAct and tgtBusy are both 0. If that condition does not occur within REL_TO ticks, the load fails with cause 2 and tgtSelect never rises.
- R4: Bytes appear on tgtData in the order they are accepted. Each byte is placed on the bus while tgtCclk is high. tgtCclk then goes low for exactly cfgHalfPeriod+1 cycles, and tgtData does not change while tgtCclk is low.
- R5: While tgtBusy is 1, inReady stays 0 and no new byte is clocked. If tgtBusy stays high for BUSY_TO ticks after a byte, the load fails with cause 3.
- R6: If tgtDone becomes 1 before the last byte is sent, streaming stops and no further byte is accepted. The load then passes if the completion condition holds.
- R7: If tgtInitAct becomes 1 while bytes are streaming, the load fails with cause 4, and errOffset equals the number of bytes clocked so far.
- R8: After the last byte, tgtSelect and tgtWrite drop and tgtCclk keeps toggling. The load passes on the first tick on which tgtDone is 1 and tgtInitAct is 0.
- R9: If completion is not seen within DONE_TO ticks after streaming ends, the load fails with cause 5.
- R10: failCause reads 0 on a pass and reads 1 to 5 on a failure. abortOut pulses for exactly one cycle when a failure is entered, and never on a pass.
- R11: A start pulse that arrives while a load is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begins a load when the block is not loading |
| cfgHalfPeriod | input | DIV_W | Configuration clock half-period, in clock cycles, minus one |
| inData | input | DATA_W | Image byte from the source |
| inValid | input | 1 | Source byte is valid |
| inLast | input | 1 | Marks the final byte of the image |
| inReady | output | 1 | Loader takes the byte in this cycle |
| tgtProg | output | 1 | Program request to the target, active high |
| tgtSelect | output | 1 | Port select, active high |
| tgtWrite | output | 1 | Write enable, active high |
| tgtCclk | output | 1 | Configuration clock; the target captures on the rising edge |
| tgtData | output | DATA_W | Byte bus to the target |
| tgtInitAct | input | 1 | Target initialisation or error line, 1 = active |
| tgtBusy | input | 1 | Target busy, 1 = busy |
| tgtDone | input | 1 | Target completion, 1 = done |
| loading | output | 1 | A load is in progress |
| passed | output | 1 | The last load succeeded |
| failed | output | 1 | The last load failed |
| abortOut | output | 1 | One-cycle pulse on entering a failure |
| failCause | output | 3 | 0 none, 1 init-assert timeout, 2 init-release timeout, 3 busy timeout, 4 mid-load error, 5 completion timeout |
| errOffset | output | CNT_W | Number of bytes clocked into the target |

## Verification
Every decision in the block is taken on a prescaler tick, so each result is due one half-period after the pin condition that causes it. A byte is due at the target on the rising configuration clock edge that follows its acceptance by cfgHalfPeriod+1 cycles. The target model in the bench therefore drives tgtDone, tgtBusy and tgtInitAct combinationally from its own count of captured bytes. The scoreboard compares each byte on the rising configuration clock edge against a queue of expected bytes. Results, counters and pin states are sampled on the falling system clock edge, and only once loading has dropped, so the checks do not depend on exact cycle counts.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_INIT,
    ST_RELEASE,
    ST_FEED,
    ST_CLK_LOW,
    ST_FIN_LOW,
    ST_FIN_HIGH,
    ST_PASS,
    ST_FAIL
  } loadState_t;

  typedef enum logic [2:0] {
    CAUSE_NONE         = 3'd0,
    CAUSE_INIT_ASSERT  = 3'd1,
    CAUSE_INIT_RELEASE = 3'd2,
    CAUSE_BUSY         = 3'd3,
    CAUSE_MIDLOAD      = 3'd4,
    CAUSE_DONE         = 3'd5
  } failCause_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic restartTick;  // realign the prescaler
    logic clrTimer;     // zero the tick timer
    logic incTimer;     // advance the tick timer
    logic takeByte;     // latch a source byte onto the bus
    logic clrCount;     // clear byte count and end flag
  } dpStrobe_t;

endpackage

// File: rtl/cfg_load_dp.sv
module cfg_load_dp
  import cfg_load_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int TMR_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DIV_W-1:0]  cfgHalfPeriod,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              tick,
  output logic [TMR_W-1:0]  timer,
  output logic              allSent,
  output logic [DATA_W-1:0] busData,
  output logic [CNT_W-1:0]  byteCount
);

  logic [DIV_W-1:0] preCnt;

  // Half-period prescaler; one tick every cfgHalfPeriod+1 cycles
  assign tick = (preCnt >= cfgHalfPeriod);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strobe.restartTick || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // Wait and timeout timer, counted in ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.clrTimer) begin
      timer <= '0;
    end else if (strobe.incTimer) begin
      timer <= timer + 1'b1;
    end
  end

  // Byte bus, byte count and end-of-image flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busData   <= '0;
      byteCount <= '0;
      allSent   <= 1'b0;
    end else if (strobe.clrCount) begin
      byteCount <= '0;
      allSent   <= 1'b0;
    end else if (strobe.takeByte) begin
      busData   <= inData;
      byteCount <= byteCount + 1'b1;
      allSent   <= inLast;
    end
  end

  // R7: the offset counter only steps by one or restarts from zero
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (byteCount != $past(byteCount)) |-> (byteCount == '0 || byteCount == $past(byteCount) + 1'b1));

endmodule

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl
  import cfg_load_pkg::*;
#(
  parameter int PROG_TICKS = 4,
  parameter int INIT_TO    = 16,
  parameter int REL_TO     = 16,
  parameter int BUSY_TO    = 32,
  parameter int DONE_TO    = 64,
  parameter int TMR_W      = 16,
  parameter bit CHECK_BUSY = 1'b1,
  parameter bit CHECK_ERR  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             inValid,
  input  logic             tgtInitAct,
  input  logic             tgtBusy,
  input  logic             tgtDone,
  input  logic             tick,
  input  logic [TMR_W-1:0] timer,
  input  logic             allSent,
  output dpStrobe_t        strobe,
  output logic             inReady,
  output logic             tgtProg,
  output logic             tgtSelect,
  output logic             tgtWrite,
  output logic             tgtCclk,
  output logic             loading,
  output logic             passed,
  output logic             failed,
  output logic             abortOut,
  output logic [2:0]       failCause
);

  localparam logic [TMR_W-1:0] PROG_LAST = TMR_W'(PROG_TICKS - 1);
  localparam logic [TMR_W-1:0] INIT_LAST = TMR_W'(INIT_TO - 1);
  localparam logic [TMR_W-1:0] REL_LAST  = TMR_W'(REL_TO - 1);
  localparam logic [TMR_W-1:0] BUSY_LAST = TMR_W'(BUSY_TO - 1);
  localparam logic [TMR_W-1:0] DONE_LAST = TMR_W'(DONE_TO - 1);

  loadState_t state, nxt;
  failCause_t causeQ, causeSel;
  logic       failNow, abortQ, startAccept;
  logic       busyHold, errHit;

  // Optional checks chosen at build time
  generate
    if (CHECK_BUSY) begin : g_busy
      assign busyHold = tgtBusy;
    end else begin : g_noBusy
      assign busyHold = 1'b0;
    end
    if (CHECK_ERR) begin : g_err
      assign errHit = tgtInitAct;
    end else begin : g_noErr
      assign errHit = 1'b0;
    end
  endgenerate

  assign startAccept = startPulse &&
                       (state == ST_IDLE || state == ST_PASS || state == ST_FAIL);

  always_comb begin
    nxt      = state;
    strobe   = '0;
    failNow  = 1'b0;
    causeSel = CAUSE_NONE;
    case (state)
      ST_IDLE, ST_PASS, ST_FAIL: begin
        if (startAccept) begin
          nxt                = ST_PROG;
          strobe.restartTick = 1'b1;
          strobe.clrTimer    = 1'b1;
          strobe.clrCount    = 1'b1;
        end
      end
      ST_PROG: begin
        if (tick) begin
          if (timer == PROG_LAST) begin
            nxt             = ST_WAIT_INIT;
            strobe.clrTimer = 1'b1;
          end else begin
            strobe.incTimer = 1'b1;
          end
        end
      end
      ST_WAIT_INIT: begin
        if (tick) begin
          if (tgtInitAct) begin
            nxt             = ST_RELEASE;
            strobe.clrTimer = 1'b1;
          end else if (timer == INIT_LAST) begin
            failNow  = 1'b1;
            causeSel = CAUSE_INIT_ASSERT;
          end else begin
            strobe.incTimer = 1'b1;
          end
        end
      end
      ST_RELEASE: begin
        if (tick) begin
          if (!tgtInitAct && !tgtBusy) begin
            nxt             = ST_FEED;
            strobe.clrTimer = 1'b1;
          end else if (timer == REL_LAST) begin
            failNow  = 1'b1;
            causeSel = CAUSE_INIT_RELEASE;
          end else begin
            strobe.incTimer = 1'b1;
          end
        end
      end
      ST_FEED: begin
        if (tick) begin
          if (tgtDone) begin
            nxt             = ST_FIN_LOW;
            strobe.clrTimer = 1'b1;
          end else if (errHit) begin
            failNow  = 1'b1;
            causeSel = CAUSE_MIDLOAD;
          end else if (busyHold) begin
            if (timer == BUSY_LAST) begin
              failNow  = 1'b1;
              causeSel = CAUSE_BUSY;
            end else begin
              strobe.incTimer = 1'b1;
            end
          end else if (allSent) begin
            nxt             = ST_FIN_LOW;
            strobe.clrTimer = 1'b1;
          end else if (inValid) begin
            nxt                = ST_CLK_LOW;
            strobe.takeByte    = 1'b1;
            strobe.restartTick = 1'b1;
            strobe.clrTimer    = 1'b1;
          end
        end
      end
      ST_CLK_LOW: begin
        if (tick) nxt = ST_FEED;
      end
      ST_FIN_LOW, ST_FIN_HIGH: begin
        if (tick) begin
          if (tgtDone && !tgtInitAct) begin
            nxt = ST_PASS;
          end else if (timer == DONE_LAST) begin
            failNow  = 1'b1;
            causeSel = CAUSE_DONE;
          end else begin
            strobe.incTimer = 1'b1;
            nxt = (state == ST_FIN_LOW) ? ST_FIN_HIGH : ST_FIN_LOW;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (failNow) nxt = ST_FAIL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      causeQ <= CAUSE_NONE;
      abortQ <= 1'b0;
    end else begin
      state  <= nxt;
      abortQ <= failNow;
      if (failNow) begin
        causeQ <= causeSel;
      end else if (startAccept) begin
        causeQ <= CAUSE_NONE;
      end
    end
  end

  assign inReady   = (state == ST_FEED) && tick && !tgtDone && !errHit &&
                     !busyHold && !allSent;
  assign tgtProg   = (state == ST_PROG) || (state == ST_WAIT_INIT);
  assign tgtSelect = (state == ST_FEED) || (state == ST_CLK_LOW);
  assign tgtWrite  = tgtSelect;
  assign tgtCclk   = !((state == ST_CLK_LOW) || (state == ST_FIN_LOW));
  assign loading   = !((state == ST_IDLE) || (state == ST_PASS) || (state == ST_FAIL));
  assign passed    = (state == ST_PASS);
  assign failed    = (state == ST_FAIL);
  assign abortOut  = abortQ;
  assign failCause = causeQ;

  // R3: the port is never selected while program is requested
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(tgtProg && tgtSelect));

  // R3: select rises only after INIT and BUSY were both seen inactive
  assert_select_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgtSelect) |-> $past(!tgtInitAct && !tgtBusy));

  // R8: a pass follows a cycle with DONE active and INIT inactive
  assert_pass_cond_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(passed) |-> $past(tgtDone && !tgtInitAct));

  // R10: abort pulse only with a latched nonzero cause
  assert_abort_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    abortOut |-> (failed && failCause != 3'd0));

  // R10: abort lasts a single cycle
  assert_abort_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    abortOut |=> !abortOut);

  // R11: program request begins only from a start taken while idle
  assert_start_only_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgtProg) |-> $past(startPulse && !loading));

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
  import cfg_load_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int TMR_W      = 16,
  parameter int CNT_W      = 16,
  parameter int PROG_TICKS = 4,
  parameter int INIT_TO    = 16,
  parameter int REL_TO     = 16,
  parameter int BUSY_TO    = 32,
  parameter int DONE_TO    = 64,
  parameter bit CHECK_BUSY = 1'b1,
  parameter bit CHECK_ERR  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [DIV_W-1:0]  cfgHalfPeriod,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              tgtProg,
  output logic              tgtSelect,
  output logic              tgtWrite,
  output logic              tgtCclk,
  output logic [DATA_W-1:0] tgtData,
  input  logic              tgtInitAct,
  input  logic              tgtBusy,
  input  logic              tgtDone,
  output logic              loading,
  output logic              passed,
  output logic              failed,
  output logic              abortOut,
  output logic [2:0]        failCause,
  output logic [CNT_W-1:0]  errOffset
);

  dpStrobe_t        strobe;
  logic             tick;
  logic [TMR_W-1:0] timer;
  logic             allSent;

  cfg_load_ctrl #(
    .PROG_TICKS (PROG_TICKS),
    .INIT_TO    (INIT_TO),
    .REL_TO     (REL_TO),
    .BUSY_TO    (BUSY_TO),
    .DONE_TO    (DONE_TO),
    .TMR_W      (TMR_W),
    .CHECK_BUSY (CHECK_BUSY),
    .CHECK_ERR  (CHECK_ERR)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .inValid    (inValid),
    .tgtInitAct (tgtInitAct),
    .tgtBusy    (tgtBusy),
    .tgtDone    (tgtDone),
    .tick       (tick),
    .timer      (timer),
    .allSent    (allSent),
    .strobe     (strobe),
    .inReady    (inReady),
    .tgtProg    (tgtProg),
    .tgtSelect  (tgtSelect),
    .tgtWrite   (tgtWrite),
    .tgtCclk    (tgtCclk),
    .loading    (loading),
    .passed     (passed),
    .failed     (failed),
    .abortOut   (abortOut),
    .failCause  (failCause)
  );

  cfg_load_dp #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W),
    .TMR_W  (TMR_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .cfgHalfPeriod (cfgHalfPeriod),
    .inData        (inData),
    .inLast        (inLast),
    .tick          (tick),
    .timer         (timer),
    .allSent       (allSent),
    .busData       (tgtData),
    .byteCount     (errOffset)
  );

  // R4: the bus holds its byte across the whole low phase of the clock
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!tgtCclk && $past(!tgtCclk)) |-> $stable(tgtData));

endmodule

// File: tb/sim_cfg_byte_loader.sv
module sim_cfg_byte_loader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [7:0]  cfgHalfPeriod = 8'd1;
  logic [7:0]  inData;
  logic        inValid, inLast, inReady;
  logic        tgtProg, tgtSelect, tgtWrite, tgtCclk;
  logic [7:0]  tgtData;
  logic        tgtInitAct, tgtBusy, tgtDone;
  logic        loading, passed, failed, abortOut;
  logic [2:0]  failCause;
  logic [15:0] errOffset;

  always #4 clk = ~clk;   // 125 MHz

  cfg_byte_loader u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .cfgHalfPeriod(cfgHalfPeriod),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .tgtProg(tgtProg), .tgtSelect(tgtSelect), .tgtWrite(tgtWrite), .tgtCclk(tgtCclk),
    .tgtData(tgtData), .tgtInitAct(tgtInitAct), .tgtBusy(tgtBusy), .tgtDone(tgtDone),
    .loading(loading), .passed(passed), .failed(failed), .abortOut(abortOut),
    .failCause(failCause), .errOffset(errOffset)
  );

  // Target model configuration (written only by the stimulus block)
  bit assertOk = 1'b1, releaseOk = 1'b1;
  int busyAt = 99, busyLen = 0, doneBytes = 99, doneExtra = 0, errAt = 99;

  // Source stream
  logic [7:0] srcBytes [16];
  int         srcCount = 0;
  int         srcIdx;
  assign inValid = (srcIdx < srcCount);
  assign inData  = srcBytes[srcIdx[3:0]];
  assign inLast  = (srcIdx == srcCount - 1);

  always @(posedge clk or negedge rstN) begin
    if (!rstN) srcIdx <= 0;
    else if (inValid && inReady) srcIdx <= srcIdx + 1;
  end

  // Target state and scoreboard monitor
  logic [7:0] expQ [$];
  int  capCount, extraEdges, busyStamp, monChecks = 0, monErrors = 0;
  bit  busyArm;
  int  cycleNow = 0;
  logic initReg;

  always @(posedge tgtCclk or negedge rstN) begin
    if (!rstN) begin
      capCount = 0; extraEdges = 0; busyArm = 1'b0; busyStamp = 0;
    end else if (tgtSelect && tgtWrite) begin
      logic [7:0] want;
      capCount = capCount + 1;
      if (capCount == busyAt) begin busyArm = 1'b1; busyStamp = cycleNow; end
      monChecks = monChecks + 1;
      if (expQ.size() == 0) begin
        monErrors = monErrors + 1;
        $display("FAIL R4 unexpected byte actual=%0h expected=none", tgtData);
      end else begin
        want = expQ.pop_front();
        if (tgtData !== want) begin
          monErrors = monErrors + 1;
          $display("FAIL R4 byte %0d actual=%0h expected=%0h", capCount, tgtData, want);
        end
      end
    end else begin
      extraEdges = extraEdges + 1;
    end
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) initReg <= 1'b0;
    else if (tgtProg && assertOk) initReg <= 1'b1;
    else if (!tgtProg && releaseOk) initReg <= 1'b0;
  end

  assign tgtInitAct = initReg || (capCount >= errAt);
  assign tgtBusy    = busyArm && ((cycleNow - busyStamp) < busyLen);
  assign tgtDone    = (capCount >= doneBytes) && (extraEdges >= doneExtra);

  // Observation counters
  int progLen, progRises, selRises, abortCount, lowRun, lastLow, readyViol;
  logic progPrev, selPrev;
  always @(posedge clk) cycleNow <= cycleNow + 1;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progLen <= 0; progRises <= 0; selRises <= 0; abortCount <= 0;
      lowRun <= 0; lastLow <= 0; progPrev <= 1'b0; selPrev <= 1'b0;
    end else begin
      progPrev <= tgtProg;
      selPrev  <= tgtSelect;
      if (tgtProg) progLen <= progLen + 1;
      if (tgtProg && !progPrev) progRises <= progRises + 1;
      if (tgtSelect && !selPrev) selRises <= selRises + 1;
      if (abortOut) abortCount <= abortCount + 1;
      if (!tgtCclk) lowRun <= lowRun + 1;
      else begin
        if (lowRun != 0) lastLow <= lowRun;
        lowRun <= 0;
      end
    end
  end
  always @(negedge clk or negedge rstN) begin
    if (!rstN) readyViol <= 0;
    else if (tgtBusy && inReady) readyViol <= readyViol + 1;
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelDefaults();
    assertOk = 1'b1; releaseOk = 1'b1;
    busyAt = 99; busyLen = 0; doneBytes = 99; doneExtra = 0; errAt = 99;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Driver: builds the source image and queues the bytes expected at the target
  task automatic prepare(input int n, input int nExp, input int seed);
    expQ.delete();
    for (int i = 0; i < 16; i++) srcBytes[i] = 8'((i * 37 + seed) ^ (i << 4));
    srcBytes[0] = 8'hFF;
    if (n > 2) srcBytes[2] = 8'h00;
    for (int i = 0; i < nExp; i++) expQ.push_back(srcBytes[i]);
    srcCount = n;
  endtask

  task automatic pulseStart();
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitIdle(input string tag);
    int guard = 0;
    @(negedge clk);
    while (loading && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 20000, {tag, " load did not end"}, guard, 0);
    @(negedge clk);
  endtask

  initial begin
    modelDefaults();
    doReset();

    // R1: reset state
    chk(tgtProg == 1'b0,   "R1 tgtProg", tgtProg, 0);
    chk(tgtSelect == 1'b0 && tgtWrite == 1'b0, "R1 select/write", tgtSelect, 0);
    chk(tgtCclk == 1'b1,   "R1 tgtCclk", tgtCclk, 1);
    chk(inReady == 1'b0,   "R1 inReady", inReady, 0);
    chk(!loading && !passed && !failed, "R1 status", {loading, passed, failed}, 0);

    // Normal load, half-period 2 cycles (R2 R4 R8 R10)
    cfgHalfPeriod = 8'd1;
    modelDefaults(); doneBytes = 6; doneExtra = 2;
    prepare(6, 6, 3);
    pulseStart();
    waitIdle("R8");
    chk(passed == 1'b1, "R8 passed", passed, 1);
    chk(failCause == 3'd0, "R10 cause on pass", failCause, 0);
    chk(capCount == 6, "R4 bytes captured", capCount, 6);
    chk(expQ.size() == 0, "R4 scoreboard drained", expQ.size(), 0);
    chk(lastLow == 2, "R4 low phase length", lastLow, 2);
    chk(progLen >= 8, "R2 program pulse width", progLen, 8);
    chk(!tgtSelect && !tgtWrite, "R8 select/write released", tgtSelect, 0);
    chk(extraEdges >= 2, "R8 clocking after data", extraEdges, 2);
    chk(abortCount == 0, "R10 no abort on pass", abortCount, 0);

    // Half-period 1 cycle with a stray start mid-load (R4 R11)
    doReset();
    cfgHalfPeriod = 8'd0;
    modelDefaults(); doneBytes = 5; doneExtra = 2;
    prepare(5, 5, 91);
    pulseStart();
    repeat (12) @(negedge clk);
    chk(loading == 1'b1, "R11 still loading", loading, 1);
    pulseStart();
    waitIdle("R11");
    chk(passed == 1'b1, "R11 passed", passed, 1);
    chk(progRises == 1, "R11 single program pulse", progRises, 1);
    chk(capCount == 5, "R11 bytes captured", capCount, 5);
    chk(lastLow == 1, "R4 low phase length fast", lastLow, 1);
    chk(progLen >= 4, "R2 program pulse width fast", progLen, 4);

    // Busy hold, half-period 4 cycles (R5)
    doReset();
    cfgHalfPeriod = 8'd3;
    modelDefaults(); doneBytes = 6; doneExtra = 2; busyAt = 2; busyLen = 24;
    prepare(6, 6, 200);
    pulseStart();
    waitIdle("R5");
    chk(passed == 1'b1, "R5 passed after busy", passed, 1);
    chk(readyViol == 0, "R5 ready while busy", readyViol, 0);
    chk(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
    chk(lastLow == 4, "R4 low phase length slow", lastLow, 4);

    // Busy stuck (R5 R10)
    doReset();
    cfgHalfPeriod = 8'd1;
    modelDefaults(); doneBytes = 6; busyAt = 2; busyLen = 1000000;
    prepare(6, 2, 17);
    pulseStart();
    waitIdle("R5");
    chk(failed && failCause == 3'd3, "R5 busy timeout cause", failCause, 3);
    chk(capCount == 2, "R5 bytes before stall", capCount, 2);
    chk(abortCount == 1, "R10 abort on busy timeout", abortCount, 1);

    // INIT never asserts (R2)
    doReset();
    modelDefaults(); assertOk = 1'b0;
    prepare(4, 0, 5);
    pulseStart();
    waitIdle("R2");
    chk(failed && failCause == 3'd1, "R2 init-assert timeout", failCause, 1);
    chk(abortCount == 1, "R10 abort on init-assert timeout", abortCount, 1);
    chk(tgtProg == 1'b0, "R2 program released on fail", tgtProg, 0);

    // INIT never releases (R3)
    doReset();
    modelDefaults(); releaseOk = 1'b0;
    prepare(4, 0, 6);
    pulseStart();
    waitIdle("R3");
    chk(failed && failCause == 3'd2, "R3 init-release timeout", failCause, 2);
    chk(selRises == 0, "R3 select never raised", selRises, 0);
    chk(abortCount == 1, "R10 abort on release timeout", abortCount, 1);

    // Mid-load error after three bytes (R7)
    doReset();
    modelDefaults(); doneBytes = 8; errAt = 3;
    prepare(8, 3, 44);
    pulseStart();
    waitIdle("R7");
    chk(failed && failCause == 3'd4, "R7 mid-load cause", failCause, 4);
    chk(errOffset == 16'd3, "R7 error offset", errOffset, 3);
    chk(abortCount == 1, "R10 abort on mid-load error", abortCount, 1);

    // Early completion after two of six bytes (R6)
    doReset();
    modelDefaults(); doneBytes = 2; doneExtra = 0;
    prepare(6, 2, 120);
    pulseStart();
    waitIdle("R6");
    chk(passed == 1'b1, "R6 pass on early done", passed, 1);
    chk(capCount == 2, "R6 bytes captured", capCount, 2);
    chk(srcIdx == 2, "R6 remaining bytes untouched", srcIdx, 2);

    // Completion never arrives (R9)
    doReset();
    modelDefaults();
    prepare(6, 6, 77);
    pulseStart();
    waitIdle("R9");
    chk(failed && failCause == 3'd5, "R9 done timeout cause", failCause, 5);
    chk(capCount == 6, "R9 all bytes sent", capCount, 6);
    chk(abortCount == 1, "R10 abort on done timeout", abortCount, 1);

    $display("CHECKS %0d ERRORS %0d", checks + monChecks, errors + monErrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks + monChecks + 1, errors + monErrors + 1);
    $finish;
  end

endmodule